// File: doc/BRIEF.md
# Reference Clock Ratio Detector

This block measures the rate of an incoming reference clock and chooses the oscillator-to-reference multiplication ratio (16, 32 or 128) that puts a clock-recovery oscillator in the 2.488 to 2.7 GHz range. No configuration pin is involved. The reference is passed through a synchronizer into a free-running measurement clock domain. Its rising edges are counted over a fixed gate window, and the count at the end of each window is sorted into one of three frequency bands. Each band is wide enough to hold both the plain line rate and the rate used with forward error correction.

Measurement never stops. Every window yields a new classification and a new activity verdict. A classification becomes the reported ratio only when two consecutive windows agree, so a single disturbed window cannot move the ratio. A window with no reference edges clears the activity flag straight away. Downstream logic can use that flag to force a loss-of-lock alarm.

Top module: `refclk_ratio_detect`

## Requirements
- R1: After reset, ratio_o reads 2'b11, and ratio_valid_o and ref_active_o are both 0.
- R2: Two consecutive windows whose counts fall in the ratio-16 band (56 to 76 edges with default parameters) produce ratio_o = 2'b00.
- R3: Two consecutive windows whose counts fall in the ratio-32 band (28 to 38 edges) produce ratio_o = 2'b01.
- R4: Two consecutive windows whose counts fall in the ratio-128 band (6 to 10 edges) produce ratio_o = 2'b10.
- R5: Two consecutive windows whose counts lie outside every band, including a count of zero, produce ratio_o = 2'b11.
- R6: ref_active_o updates at the end of every window. It goes to 0 after a window with no rising reference edge and to 1 after a window with at least one.
- R7: ratio_o takes a new value only when the classifications of the two most recent windows are equal. A single window in a different band leaves ratio_o unchanged.
- R8: ratio_valid_o is 1 exactly when ratio_o is not 2'b11.
- R9: ratio_o and ref_active_o change only in the cycle after a window ends. A window lasts WIN_CYCLES measurement-clock cycles and starts at reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running measurement clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_clk_i | input | 1 | Reference clock, sampled asynchronously |
| ratio_o | output | 2 | Selected ratio: 00=16, 01=32, 10=128, 11=none |
| ratio_valid_o | output | 1 | High when ratio_o holds a supported ratio |
| ref_active_o | output | 1 | High when the last window saw reference edges |

## Verification
The bench sweeps the reference rate one edge per window at a time, from a few edges up to far above the top band. This exposes an off-by-one band limit, which would misclassify the first or last edge count of a band. It also exposes a swapped code, which would report the wrong ratio for an entire band. Three explicit cases use the faster error-correction rates, so a band cut too narrow would fail to recognise them. In the glitch case, one gate window runs at the ratio-16 rate while the baseline is ratio 32. A design without the two-window agreement would flip the ratio for one window, and the bench detects this by monitoring ratio_o on every cycle. A stopped reference has to clear the activity flag and end with ratio_o at invalid, because a design that ignores a zero count would keep reporting the stale ratio.

// File: rtl/refclk_ratio_pkg.sv
package refclk_ratio_pkg;
  typedef enum logic [1:0] {
    RATIO_16   = 2'b00,
    RATIO_32   = 2'b01,
    RATIO_128  = 2'b10,
    RATIO_NONE = 2'b11
  } ratio_e;

  localparam int unsigned NUM_BANDS = 3;
endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_clk_i,
  output logic rise_o
);
  localparam int unsigned DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '0;
    else         shift_q <= {shift_q[DEPTH-2:0], ref_clk_i};
  end

  // edge seen between the last synchronized stage and the extra history flop
  assign rise_o = shift_q[DEPTH-2] & ~shift_q[DEPTH-1];
endmodule

// File: rtl/gate_counter.sv
module gate_counter #(
  parameter int unsigned WIN_CYCLES = 256,
  parameter int unsigned CNT_W      = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             vld_o
);
  localparam int unsigned TIM_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [TIM_W-1:0] LAST = TIM_W'(WIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] SAT  = '1;

  logic [TIM_W-1:0] tim_q;
  logic [CNT_W-1:0] edge_q, edge_nxt, cnt_q;
  logic             vld_q;
  logic             last;

  assign last     = (tim_q == LAST);
  assign edge_nxt = (rise_i && edge_q != SAT) ? edge_q + 1'b1 : edge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_q  <= '0;
      edge_q <= '0;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= last;
      if (last) begin
        tim_q  <= '0;
        edge_q <= '0;
        cnt_q  <= edge_nxt;
      end else begin
        tim_q  <= tim_q + 1'b1;
        edge_q <= edge_nxt;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/band_classifier.sv
module band_classifier
  import refclk_ratio_pkg::*;
#(
  parameter int unsigned CNT_W   = 9,
  parameter int unsigned B16_LO  = 56,
  parameter int unsigned B16_HI  = 76,
  parameter int unsigned B32_LO  = 28,
  parameter int unsigned B32_HI  = 38,
  parameter int unsigned B128_LO = 6,
  parameter int unsigned B128_HI = 10
) (
  input  logic [CNT_W-1:0] cnt_i,
  output ratio_e           code_o
);
  localparam int unsigned LO [NUM_BANDS] = '{B16_LO, B32_LO, B128_LO};
  localparam int unsigned HI [NUM_BANDS] = '{B16_HI, B32_HI, B128_HI};

  logic [NUM_BANDS-1:0] hit;

  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    assign hit[b] = (cnt_i >= CNT_W'(LO[b])) && (cnt_i <= CNT_W'(HI[b]));
  end

  always_comb begin
    code_o = RATIO_NONE;
    if      (hit[0]) code_o = RATIO_16;
    else if (hit[1]) code_o = RATIO_32;
    else if (hit[2]) code_o = RATIO_128;
  end
endmodule

// File: rtl/ratio_filter.sv
module ratio_filter
  import refclk_ratio_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   upd_i,
  input  ratio_e code_i,
  input  logic   idle_i,
  output ratio_e cand_o,
  output ratio_e ratio_o,
  output logic   active_o
);
  ratio_e cand_q, ratio_q;
  logic   active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q   <= RATIO_NONE;
      ratio_q  <= RATIO_NONE;
      active_q <= 1'b0;
    end else if (upd_i) begin
      cand_q   <= code_i;
      active_q <= !idle_i;
      if (code_i == cand_q) ratio_q <= code_i;
    end
  end

  assign cand_o   = cand_q;
  assign ratio_o  = ratio_q;
  assign active_o = active_q;
endmodule

// File: rtl/refclk_ratio_detect.sv
module refclk_ratio_detect
  import refclk_ratio_pkg::*;
#(
  parameter int unsigned WIN_CYCLES  = 256,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned B16_LO      = 56,
  parameter int unsigned B16_HI      = 76,
  parameter int unsigned B32_LO      = 28,
  parameter int unsigned B32_HI      = 38,
  parameter int unsigned B128_LO     = 6,
  parameter int unsigned B128_HI     = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_clk_i,
  output logic [1:0] ratio_o,
  output logic       ratio_valid_o,
  output logic       ref_active_o
);
  localparam int unsigned CNT_W = $clog2(WIN_CYCLES + 1);

  logic             rise;
  logic [CNT_W-1:0] meas_cnt;
  logic             meas_vld;
  ratio_e           band_code, cand_code, ratio_sel;

  ref_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ref_clk_i(ref_clk_i),
    .rise_o   (rise)
  );

  gate_counter #(.WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rise_i(rise),
    .cnt_o (meas_cnt),
    .vld_o (meas_vld)
  );

  band_classifier #(
    .CNT_W(CNT_W),
    .B16_LO(B16_LO),   .B16_HI(B16_HI),
    .B32_LO(B32_LO),   .B32_HI(B32_HI),
    .B128_LO(B128_LO), .B128_HI(B128_HI)
  ) u_class (
    .cnt_i (meas_cnt),
    .code_o(band_code)
  );

  ratio_filter u_filt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (meas_vld),
    .code_i  (band_code),
    .idle_i  (meas_cnt == '0),
    .cand_o  (cand_code),
    .ratio_o (ratio_sel),
    .active_o(ref_active_o)
  );

  assign ratio_o       = ratio_sel;
  assign ratio_valid_o = (ratio_sel != RATIO_NONE);
endmodule

// File: rtl/refclk_ratio_detect_chk.sv
module refclk_ratio_detect_chk #(
  parameter int unsigned CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             meas_vld,
  input logic [CNT_W-1:0] meas_cnt,
  input logic [1:0]       band_code,
  input logic [1:0]       cand_code,
  input logic [1:0]       ratio_o,
  input logic             ref_active_o
);
  AST_HOLD_OFF_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !meas_vld |=> ($stable(ratio_o) && $stable(ref_active_o))); // R9

  AST_DISAGREE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_vld && band_code != cand_code) |=> $stable(ratio_o)); // R7

  AST_AGREE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_vld && band_code == cand_code) |=> (ratio_o == $past(band_code))); // R7

  AST_IDLE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_vld && meas_cnt == '0) |=> !ref_active_o); // R6

  AST_EDGE_RAISES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_vld && meas_cnt != '0) |=> ref_active_o); // R6

  AST_ZERO_NO_BAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_cnt == '0) |-> (band_code == 2'b11)); // R5
endmodule

bind refclk_ratio_detect refclk_ratio_detect_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .meas_vld    (meas_vld),
  .meas_cnt    (meas_cnt),
  .band_code   (band_code),
  .cand_code   (cand_code),
  .ratio_o     (ratio_o),
  .ref_active_o(ref_active_o)
);

// File: tb/refclk_ratio_detect_tb_top.sv
module refclk_ratio_detect_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 256;
  localparam int SETTLE     = 3 * WIN + 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_clk;
  logic [1:0]  ratio;
  logic        ratio_valid;
  logic        ref_active;
  logic [15:0] acc = '0;
  logic [15:0] inc = '0;
  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference synthesized from a phase accumulator: WIN*inc/65536 edges per window
  always @(negedge clk) acc <= acc + inc;
  assign ref_clk = acc[15];

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  refclk_ratio_detect dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .ref_clk_i    (ref_clk),
    .ratio_o      (ratio),
    .ratio_valid_o(ratio_valid),
    .ref_active_o (ref_active)
  );

  function automatic int band_of(int n);
    if (n >= 56 && n <= 76) return 0;
    if (n >= 28 && n <= 38) return 1;
    if (n >= 6  && n <= 10) return 2;
    return 3;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_and_check(string req, int exp_code, int exp_act);
    wait_cycles(SETTLE);
    chk(req, ratio, exp_code);
    chk("R8", ratio_valid, exp_code != 3);
    chk("R6", ref_active, exp_act);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    bit glitch_moved;
    wait_cycles(3);
    chk("R1", ratio, 3);
    chk("R1", ratio_valid, 0);
    chk("R1", ref_active, 0);
    @(negedge clk) rst_n = 1'b1;

    // sweep edges-per-window e: count lands on e or e+1
    for (int e = 2; e <= 90; e++) begin
      int c0, c1;
      inc = 16'(e * 256 + 128);
      c0 = band_of(e);
      c1 = band_of(e + 1);
      if (c0 == c1) begin
        case (c0)
          0: settle_and_check("R2", 0, 1);
          1: settle_and_check("R3", 1, 1);
          2: settle_and_check("R4", 2, 1);
          default: settle_and_check("R5", 3, 1);
        endcase
      end else begin
        wait_cycles(SETTLE);
      end
    end

    // faster error-correction rates
    inc = 16'd17554; settle_and_check("R2", 0, 1);
    inc = 16'd8777;  settle_and_check("R3", 1, 1);
    inc = 16'd2194;  settle_and_check("R4", 2, 1);

    // single window at the ratio-16 rate over a ratio-32 baseline
    inc = 16'(32 * 256 + 128);
    settle_and_check("R3", 1, 1);
    while ((cyc % WIN) != 0) @(negedge clk);
    glitch_moved = 1'b0;
    inc = 16'(64 * 256 + 128);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (ratio != 2'b01) glitch_moved = 1'b1;
    end
    inc = 16'(32 * 256 + 128);
    for (int i = 0; i < 3 * WIN; i++) begin
      @(negedge clk);
      if (ratio != 2'b01) glitch_moved = 1'b1;
    end
    chk("R7", glitch_moved, 0);
    chk("R7", ratio, 1);

    // reference stops
    inc = '0;
    settle_and_check("R5", 3, 0);

    // reference returns
    inc = 16'(8 * 256 + 128);
    settle_and_check("R4", 2, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule